// File: doc/BRIEF.md
# Card Data Transfer Length Controller

This block holds the data-transfer configuration of a memory-card host data path and counts the bytes of each transfer. A control byte carries a block-size code, a transfer mode, a direction bit and an enable bit. A separate register holds the requested data length. When the data path leaves idle, the block works out the effective length and loads it into a down-counter. The counter then drops by one for each transferred byte.

A transfer starts in one of two ways. Software can set the enable bit, which starts a transfer without a command. The command side can instead pulse a start input. For block modes, the length is cut down to a whole number of blocks, and a cut length of zero completes at once. A reserved size code, or a zero size code in double-data-rate mode, is refused with an error flag. The control byte is locked while a transfer is running. The enable bit clears itself when a transfer completes or is refused.

Top module: `cardLenCtrl`

## Requirements
- R1: After reset, `ctlRd`, `count`, `active`, `waitRx`, `waitTx`, `done` and `cfgErr` are all 0.
- R2: A control write is accepted when the block is idle and no start is being taken in that cycle. The control byte layout is: bits [3:0] size code n (block = 2^n bytes, n = 0..14), bits [5:4] mode, bit 6 direction (1 = card to host), bit 7 enable. `ctlRd` returns the byte that was stored.
- R3: A control write while `active` is 1 is ignored, and `ctlRd` keeps its value.
- R4: The edge after the enable bit is set in idle, `active` rises and `count` holds the effective length. `waitRx` is 1 when the direction bit is 1, and `waitTx` is 1 otherwise.
- R5: With the enable bit at 0, the block stays idle. A one-cycle `cmdStart` pulse in idle starts a transfer in the same way as the enable bit.
- R6: In modes 2'b00 (block, ends on count) and 2'b11 (block, ends on stop), the effective length is the length with its low n bits cleared. In modes 2'b01 (multibyte) and 2'b10 (stream), the effective length is the full length. `effLen` shows this value.
- R7: While `active` is 1, each cycle with `byteStb` high lowers `count` by one, and a cycle without `byteStb` leaves it unchanged. `byteStb` has no effect in idle.
- R8: On the edge where `count` goes from 1 to 0, the block does three things: `done` is 1 for exactly one cycle, `active` drops, and the enable bit in `ctlRd` clears.
- R9: A start whose effective length is 0 gives a one-cycle `done` on the start edge. `active` never rises, and the enable bit clears.
- R10: A start with size code 15 sets `cfgErr`, does not raise `active`, and clears the enable bit.
- R11: A start with `ddrMode` high and size code 0 sets `cfgErr` and does not raise `active`. `cfgErr` stays set until the next accepted control write clears it.
- R12: A length write is accepted at any time and does not disturb a running `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control byte write strobe |
| ctlWrData | input | 8 | Control byte to write |
| lenWrEn | input | 1 | Length register write strobe |
| lenWrData | input | LEN_W | Requested data length in bytes |
| ddrMode | input | 1 | Double-data-rate bus mode is selected |
| cmdStart | input | 1 | Start pulse from the command side |
| byteStb | input | 1 | One byte moved this cycle |
| ctlRd | output | 8 | Stored control byte |
| effLen | output | LEN_W | Effective length after block truncation |
| count | output | LEN_W | Remaining byte count |
| active | output | 1 | A transfer is running |
| waitRx | output | 1 | Running, card to host |
| waitTx | output | 1 | Running, host to card |
| done | output | 1 | One-cycle completion pulse |
| cfgErr | output | 1 | Invalid configuration was refused |

## Verification
The properties assume that every input changes only between clock edges. They also assume that `cmdStart` is a single-cycle pulse given only when the block is idle. They allow `byteStb` to come at any time and still expect idle strobes to be ignored. The stimulus follows these rules. It drives every input on the falling edge, pulses `cmdStart` only after the previous transfer has reported `done`, and keeps the lengths small so that each transfer ends within a few dozen strobes.

// File: rtl/cardLenPkg.sv
package cardLenPkg;

  typedef enum logic [1:0] {
    MODE_BLK_CNT  = 2'b00,
    MODE_MULTI    = 2'b01,
    MODE_STREAM   = 2'b10,
    MODE_BLK_STOP = 2'b11
  } xferMode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_WAIT_RX = 2'b01,
    ST_WAIT_TX = 2'b10
  } dpState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic ctlWr;
    logic load;
    logic dec;
    logic clrEn;
    logic setErr;
  } pathStb_t;

endpackage

// File: rtl/cardLenPath.sv
module cardLenPath
  import cardLenPkg::*;
#(
  parameter int LEN_W    = 25,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathStb_t         stb,
  input  logic [7:0]       ctlWrData,
  input  logic             lenWrEn,
  input  logic [LEN_W-1:0] lenWrData,
  input  logic             ddrMode,
  output logic             enBit,
  output logic             dirBit,
  output logic             cfgBad,
  output logic             effZero,
  output logic             cntOne,
  output logic [7:0]       ctlRd,
  output logic [LEN_W-1:0] effLen,
  output logic [LEN_W-1:0] count,
  output logic             cfgErr
);

  localparam logic [LEN_W-1:0] ALL_ONES = '1;
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

  logic [CODE_W-1:0] sizeCode;
  xferMode_e         mode;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  blkMask;
  logic              blockMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeCode <= '0;
      mode     <= MODE_BLK_CNT;
      dirBit   <= 1'b0;
      enBit    <= 1'b0;
      cfgErr   <= 1'b0;
    end else if (stb.ctlWr) begin
      sizeCode <= ctlWrData[CODE_W-1:0];
      mode     <= xferMode_e'(ctlWrData[5:4]);
      dirBit   <= ctlWrData[6];
      enBit    <= ctlWrData[7];
      cfgErr   <= 1'b0;
    end else begin
      if (stb.clrEn)  enBit  <= 1'b0;
      if (stb.setErr) cfgErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        lenReg <= '0;
    else if (lenWrEn) lenReg <= lenWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (stb.load) count <= effLen;
    else if (stb.dec)  count <= count - ONE;
  end

  always_comb begin
    blockMode = (mode == MODE_BLK_CNT) || (mode == MODE_BLK_STOP);
    blkMask   = ALL_ONES << sizeCode;
    effLen    = blockMode ? (lenReg & blkMask) : lenReg;
    effZero   = (effLen == '0);
    cfgBad    = (int'(sizeCode) > MAX_CODE) || (ddrMode && (sizeCode == '0));
    cntOne    = (count == ONE);
    ctlRd     = {enBit, dirBit, mode, sizeCode};
  end

endmodule

// File: rtl/cardLenFsm.sv
module cardLenFsm
  import cardLenPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctlWrEn,
  input  logic     cmdStart,
  input  logic     byteStb,
  input  logic     enBit,
  input  logic     dirBit,
  input  logic     cfgBad,
  input  logic     effZero,
  input  logic     cntOne,
  output pathStb_t stb,
  output logic     active,
  output logic     waitRx,
  output logic     waitTx,
  output logic     done
);

  dpState_e state, stateNext;
  logic     startNow;
  logic     doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    stb       = '0;
    startNow  = (state == ST_IDLE) && (enBit || cmdStart);
    stb.ctlWr = ctlWrEn && (state == ST_IDLE) && !startNow;
    if (startNow) begin
      if (cfgBad) begin
        stb.setErr = 1'b1;
        stb.clrEn  = 1'b1;
      end else if (effZero) begin
        stb.clrEn = 1'b1;
        doneNext  = 1'b1;
      end else begin
        stb.load  = 1'b1;
        stateNext = dirBit ? ST_WAIT_RX : ST_WAIT_TX;
      end
    end else if ((state != ST_IDLE) && byteStb) begin
      stb.dec = 1'b1;
      if (cntOne) begin
        stb.clrEn = 1'b1;
        doneNext  = 1'b1;
        stateNext = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  always_comb begin
    waitRx = (state == ST_WAIT_RX);
    waitTx = (state == ST_WAIT_TX);
    active = waitRx || waitTx;
  end

endmodule

// File: rtl/cardLenCtrl.sv
module cardLenCtrl
  import cardLenPkg::*;
#(
  parameter int LEN_W    = 25,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  input  logic             lenWrEn,
  input  logic [LEN_W-1:0] lenWrData,
  input  logic             ddrMode,
  input  logic             cmdStart,
  input  logic             byteStb,
  output logic [7:0]       ctlRd,
  output logic [LEN_W-1:0] effLen,
  output logic [LEN_W-1:0] count,
  output logic             active,
  output logic             waitRx,
  output logic             waitTx,
  output logic             done,
  output logic             cfgErr
);

  pathStb_t stb;
  logic     enBit, dirBit, cfgBad, effZero, cntOne;

  cardLenFsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrEn  (ctlWrEn),
    .cmdStart (cmdStart),
    .byteStb  (byteStb),
    .enBit    (enBit),
    .dirBit   (dirBit),
    .cfgBad   (cfgBad),
    .effZero  (effZero),
    .cntOne   (cntOne),
    .stb      (stb),
    .active   (active),
    .waitRx   (waitRx),
    .waitTx   (waitTx),
    .done     (done)
  );

  cardLenPath #(
    .LEN_W    (LEN_W),
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ctlWrData (ctlWrData),
    .lenWrEn   (lenWrEn),
    .lenWrData (lenWrData),
    .ddrMode   (ddrMode),
    .enBit     (enBit),
    .dirBit    (dirBit),
    .cfgBad    (cfgBad),
    .effZero   (effZero),
    .cntOne    (cntOne),
    .ctlRd     (ctlRd),
    .effLen    (effLen),
    .count     (count),
    .cfgErr    (cfgErr)
  );

endmodule

// File: rtl/cardLenCtrlChecker.sv
module cardLenCtrlChecker #(
  parameter int LEN_W = 25
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWrEn,
  input logic             byteStb,
  input logic [7:0]       ctlRd,
  input logic [LEN_W-1:0] count,
  input logic             active,
  input logic             waitRx,
  input logic             waitTx,
  input logic             done,
  input logic             cfgErr
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  p_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && ctlWrEn && !(byteStb && count == ONE)) |=> $stable(ctlRd));

  p_one_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({waitRx, waitTx}));

  p_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    (active && byteStb && count != ONE) |=> (active && count == $past(count) - ONE));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (active && !byteStb) |=> $stable(count));

  p_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    (active && byteStb && count == ONE) |=> (done && !active && count == '0));

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!active && !ctlRd[7]));

  p_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (count != '0));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> (!active && !ctlRd[7]));

endmodule

bind cardLenCtrl cardLenCtrlChecker #(.LEN_W(LEN_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctlWrEn (ctlWrEn),
  .byteStb (byteStb),
  .ctlRd   (ctlRd),
  .count   (count),
  .active  (active),
  .waitRx  (waitRx),
  .waitTx  (waitTx),
  .done    (done),
  .cfgErr  (cfgErr)
);

// File: tb/cardLenCtrl_bench.sv
module cardLenCtrl_bench;
  localparam int LEN_W = 25;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ctlWrEn = 1'b0;
  logic [7:0]       ctlWrData = '0;
  logic             lenWrEn = 1'b0;
  logic [LEN_W-1:0] lenWrData = '0;
  logic             ddrMode = 1'b0;
  logic             cmdStart = 1'b0;
  logic             byteStb = 1'b0;
  logic [7:0]       ctlRd;
  logic [LEN_W-1:0] effLen;
  logic [LEN_W-1:0] count;
  logic             active, waitRx, waitTx, done, cfgErr;

  always #5 clk = ~clk;

  cardLenCtrl #(.LEN_W(LEN_W)) u_cardLenCtrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData), .ddrMode(ddrMode),
    .cmdStart(cmdStart), .byteStb(byteStb), .ctlRd(ctlRd), .effLen(effLen),
    .count(count), .active(active), .waitRx(waitRx), .waitTx(waitTx),
    .done(done), .cfgErr(cfgErr)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    longint len;
    bit     rx;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t curItem;
  logic     prevActive = 1'b0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: each start pops one expected transfer
  always @(negedge clk) begin
    if (rstN && active && !prevActive) begin
      if (expQ.size() == 0) begin
        check("R4", "unexpected start", 1, 0);
      end else begin
        curItem = expQ.pop_front();
        check("R4/R6", "loaded count", longint'(count), curItem.len);
        check("R4", "waitRx", longint'(waitRx), longint'(curItem.rx));
        check("R4", "waitTx", longint'(waitTx), longint'(!curItem.rx));
      end
    end
    prevActive = active;
  end

  task automatic expectXfer(longint len, bit rx);
    expItem_t it;
    it.len = len;
    it.rx  = rx;
    expQ.push_back(it);
  endtask

  task automatic writeCtl(logic [7:0] d);
    @(negedge clk);
    ctlWrEn   = 1'b1;
    ctlWrData = d;
    @(negedge clk);
    ctlWrEn   = 1'b0;
  endtask

  task automatic writeLen(int l);
    @(negedge clk);
    lenWrEn   = 1'b1;
    lenWrData = LEN_W'(l);
    @(negedge clk);
    lenWrEn   = 1'b0;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      byteStb = 1'b1;
      @(negedge clk);
    end
    byteStb = 1'b0;
  endtask

  task automatic checkDone(string req, logic [7:0] ctlExp);
    check(req, "done", longint'(done), 1);
    check(req, "active after done", longint'(active), 0);
    check(req, "enable cleared", longint'(ctlRd), longint'(ctlExp));
    @(negedge clk);
    check(req, "done one cycle", longint'(done), 0);
  endtask

  initial begin
    #1_000_000;
    check("WATCHDOG", "timeout", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ctlRd", longint'(ctlRd), 0);
    check("R1", "count", longint'(count), 0);
    check("R1", "active", longint'({active, waitRx, waitTx}), 0);
    check("R1", "done/cfgErr", longint'({done, cfgErr}), 0);
    rstN = 1'b1;

    // R7: byte strobes in idle do nothing
    @(negedge clk);
    strobe(2);
    check("R7", "idle strobe count", longint'(count), 0);

    // block mode, code 2 (4 bytes), length 10 -> 8, host to card
    writeLen(10);
    expectXfer(8, 1'b0);
    writeCtl(8'h82);
    check("R2", "ctlRd stored", longint'(ctlRd), 8'h82);
    @(negedge clk);
    check("R4", "active", longint'(active), 1);
    strobe(3);
    check("R7", "count after 3", longint'(count), 5);
    @(negedge clk);
    check("R7", "count held", longint'(count), 5);
    writeCtl(8'h00);
    check("R3", "locked ctlRd", longint'(ctlRd), 8'h82);
    writeLen(101);
    check("R12", "count kept", longint'(count), 5);
    check("R6", "effLen block truncate", longint'(effLen), 100);
    strobe(4);
    check("R7", "count at one", longint'(count), 1);
    check("R8", "no early done", longint'(done), 0);
    strobe(1);
    checkDone("R8", 8'h02);

    // multibyte, card to host, no truncation
    writeLen(10);
    expectXfer(10, 1'b1);
    writeCtl(8'hD2);
    @(negedge clk);
    check("R6", "multibyte effLen", longint'(effLen), 10);
    strobe(10);
    checkDone("R8", 8'h52);

    // stream, code 0
    writeLen(5);
    expectXfer(5, 1'b0);
    writeCtl(8'hA0);
    @(negedge clk);
    strobe(5);
    checkDone("R8", 8'h20);

    // block ending on stop, code 3, length 20 -> 16, card to host
    writeLen(20);
    expectXfer(16, 1'b1);
    writeCtl(8'hF3);
    @(negedge clk);
    strobe(16);
    checkDone("R8", 8'h73);

    // R5: command start with enable clear
    writeLen(7);
    writeCtl(8'h01);
    @(negedge clk);
    check("R5", "no start without enable", longint'(active), 0);
    expectXfer(6, 1'b0);
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    check("R5", "cmd start active", longint'(active), 1);
    strobe(6);
    checkDone("R8", 8'h01);

    // R9: truncated length zero
    writeLen(10);
    writeCtl(8'h84);
    @(negedge clk);
    check("R9", "zero length done", longint'(done), 1);
    check("R9", "never active", longint'(active), 0);
    check("R9", "enable cleared", longint'(ctlRd), 8'h04);
    @(negedge clk);
    check("R9", "done one cycle", longint'(done), 0);

    // R10: reserved code
    writeCtl(8'h8F);
    @(negedge clk);
    check("R10", "cfgErr", longint'(cfgErr), 1);
    check("R10", "not active", longint'(active), 0);
    check("R10", "enable cleared", longint'(ctlRd), 8'h0F);
    writeCtl(8'h02);
    check("R11", "cfgErr cleared by write", longint'(cfgErr), 0);

    // R11: DDR with size code 0
    ddrMode = 1'b1;
    writeCtl(8'h90);
    @(negedge clk);
    check("R11", "ddr zero cfgErr", longint'(cfgErr), 1);
    check("R11", "ddr not active", longint'(active), 0);
    @(negedge clk);
    check("R11", "cfgErr sticky", longint'(cfgErr), 1);

    // DDR with a valid code still runs
    writeLen(4);
    expectXfer(4, 1'b0);
    writeCtl(8'h82);
    check("R11", "cfgErr cleared", longint'(cfgErr), 0);
    @(negedge clk);
    strobe(4);
    checkDone("R8", 8'h02);
    ddrMode = 1'b0;

    check("R4", "all expected starts seen", longint'(expQ.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule